// File: doc/BRIEF.md
# Windowed Command and Status Port for an Ethernet Controller

This block is the host-facing control point of a simple Ethernet controller. The host writes 16-bit command words into one port. Each word is split into a 5-bit opcode in bits 15..11 and an 11-bit argument in bits 10..0. A command can select a register window, acknowledge or request events, load the interrupt mask or the read-visibility mask, load one of three FIFO thresholds, switch the receiver and transmitter on or off, or start a timed global reset. Commands that take no argument ignore the argument bits.

The datapath reports events as single-cycle pulses. The block latches each pulse into a status bit until software acknowledges it. The status word is always available for reading. It carries the current window number, a busy flag and the latched event bits, gated by the read-visibility mask. An interrupt output is raised when any enabled event is latched.

Top module: `nic_cmd_status`

## Requirements
- R1: After reset, the window is 0, the receiver and transmitter are off, no event is latched, `status` reads 0 and `irq` is low. The interrupt mask is 0, the read-visibility mask is 8'hFF, and all three thresholds hold 2047 with their enable flags low.
- R2: Opcode 1 sets the window to argument bits 2..0. Upper argument bits are ignored. The window reads back in `status[15:13]`.
- R3: Each event pulse sets its status bit and the bit stays set until acknowledged. The bit positions are: adapter failure 1, TX complete 2, TX available 3, RX complete 4, RX early 5, update statistics 7.
- R4: Opcode 13 clears each latched bit in positions 1..7 whose position is set in argument bits 7..0. An event pulse arriving in the same cycle as the clear keeps its bit set.
- R5: Opcode 12 sets status bit 6 (interrupt requested).
- R6: `irq` is high exactly when a latched bit in positions 1..7 is also set in the interrupt mask. Status bit 0 reports the same condition.
- R7: Opcode 14 loads the interrupt mask from argument bits 7..0. Opcode 15 loads the read-visibility mask from the same bits. A status bit whose visibility-mask bit is 0 reads 0, but it stays latched and reappears when its mask bit is set again.
- R8: Opcodes 17, 18 and 19 load the RX-early, TX-available and TX-start thresholds from the 11-bit argument. Each threshold's enable flag is low exactly when its value is 2047.
- R9: Opcodes 3 and 4 turn the receiver off and on. Opcodes 9 and 10 turn the transmitter on and off.
- R10: Opcode 0 sets `status[12]` for RESET_HOLD cycles, and commands written during that time are ignored. Afterwards every register returns to its R1 value.
- R11: Opcodes not listed above (for example 2, 5, 8, 11 and 16) change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: opcode in 15..11, argument in 10..0 |
| ev_fail | input | 1 | Adapter failure pulse |
| ev_tx_done | input | 1 | Transmit complete pulse |
| ev_tx_avail | input | 1 | Transmit space available pulse |
| ev_rx_done | input | 1 | Receive complete pulse |
| ev_rx_early | input | 1 | Receive early pulse |
| ev_stats | input | 1 | Statistics update pulse |
| status | output | 16 | Window, busy flag and visible event bits |
| irq | output | 1 | Interrupt request |
| rx_en | output | 1 | Receiver enabled |
| tx_en | output | 1 | Transmitter enabled |
| rx_early_th | output | 11 | RX-early threshold |
| tx_avail_th | output | 11 | TX-available threshold |
| tx_start_th | output | 11 | TX-start threshold |
| rx_early_on | output | 1 | RX-early threshold active |
| tx_avail_on | output | 1 | TX-available threshold active |
| tx_start_on | output | 1 | TX-start threshold active |

## Verification
The bench builds the block with RESET_HOLD set to 6 instead of the default 2000. With that value the bench can follow the global-reset busy window cycle by cycle. It can confirm the exact cycle in which `status[12]` falls, and it can show that a window-select written in the middle of the hold is dropped. The default threshold width and event layout are kept, so the 2047 disable value and all bit positions are checked as they are.

// File: rtl/nic_cmd_status.sv
module nic_cmd_status #(
  parameter int RESET_HOLD = 2000,
  localparam int CW = $clog2(RESET_HOLD + 1),
  localparam int TW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [15:0]   cmd_data,
  input  logic          ev_fail,
  input  logic          ev_tx_done,
  input  logic          ev_tx_avail,
  input  logic          ev_rx_done,
  input  logic          ev_rx_early,
  input  logic          ev_stats,
  output logic [15:0]   status,
  output logic          irq,
  output logic          rx_en,
  output logic          tx_en,
  output logic [TW-1:0] rx_early_th,
  output logic [TW-1:0] tx_avail_th,
  output logic [TW-1:0] tx_start_th,
  output logic          rx_early_on,
  output logic          tx_avail_on,
  output logic          tx_start_on
);
  localparam logic [4:0] OP_GRST = 5'd0,  OP_WIN  = 5'd1,  OP_RXOFF = 5'd3,
                         OP_RXON = 5'd4,  OP_TXON = 5'd9,  OP_TXOFF = 5'd10,
                         OP_REQ  = 5'd12, OP_ACK  = 5'd13, OP_IMASK = 5'd14,
                         OP_VMASK = 5'd15, OP_THRE = 5'd17, OP_THTA = 5'd18,
                         OP_THTS = 5'd19;
  localparam logic [TW-1:0] TH_OFF = '1;

  logic [2:0]    win_q;
  logic [7:1]    ev_q;
  logic [7:1]    imask_q;
  logic [7:0]    vmask_q;
  logic [CW-1:0] cnt_q;

  wire [4:0]    op   = cmd_data[15:11];
  wire [TW-1:0] arg  = cmd_data[10:0];
  wire          busy = cnt_q != '0;
  wire          go   = cmd_we && !busy;
  wire          done = cnt_q == CW'(1);

  wire [7:1] set_v = {ev_stats, go && op == OP_REQ, ev_rx_early, ev_rx_done,
                      ev_tx_avail, ev_tx_done, ev_fail};
  wire [7:1] clr_v = (go && op == OP_ACK) ? arg[7:1] : 7'd0;

  assign irq         = |(ev_q & imask_q);
  assign status      = {win_q, busy, 4'd0, {ev_q, irq} & vmask_q};
  assign rx_early_on = rx_early_th != TH_OFF;
  assign tx_avail_on = tx_avail_th != TH_OFF;
  assign tx_start_on = tx_start_th != TH_OFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0; ev_q <= '0; imask_q <= '0; vmask_q <= '1; cnt_q <= '0;
      rx_en <= 1'b0; tx_en <= 1'b0;
      rx_early_th <= TH_OFF; tx_avail_th <= TH_OFF; tx_start_th <= TH_OFF;
    end else if (done) begin
      win_q <= '0; ev_q <= '0; imask_q <= '0; vmask_q <= '1; cnt_q <= '0;
      rx_en <= 1'b0; tx_en <= 1'b0;
      rx_early_th <= TH_OFF; tx_avail_th <= TH_OFF; tx_start_th <= TH_OFF;
    end else begin
      ev_q <= (ev_q & ~clr_v) | set_v;
      if (busy) cnt_q <= cnt_q - CW'(1);
      if (go) begin
        case (op)
          OP_GRST:  cnt_q       <= CW'(RESET_HOLD);
          OP_WIN:   win_q       <= arg[2:0];
          OP_RXOFF: rx_en       <= 1'b0;
          OP_RXON:  rx_en       <= 1'b1;
          OP_TXON:  tx_en       <= 1'b1;
          OP_TXOFF: tx_en       <= 1'b0;
          OP_IMASK: imask_q     <= arg[7:1];
          OP_VMASK: vmask_q     <= arg[7:0];
          OP_THRE:  rx_early_th <= arg;
          OP_THTA:  tx_avail_th <= arg;
          OP_THTS:  tx_start_th <= arg;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nic_cmd_status_chk.sv
module nic_cmd_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic [15:0] cmd_data,
  input logic [15:0] status,
  input logic        irq,
  input logic        rx_en,
  input logic        tx_en,
  input logic [7:1]  ev_q,
  input logic [7:0]  vmask_q,
  input logic        ev_tx_done,
  input logic [10:0] rx_early_th
);
  wire go = cmd_we && !status[12];

  a_r2_window_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_data[15:11] == 5'd1 |=> status[15:13] == $past(cmd_data[2:0]));
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_data[15:11] == 5'd13 && cmd_data[2] && !ev_tx_done |=> !ev_q[2]);
  a_r5_reqint_sets: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_data[15:11] == 5'd12 |=> ev_q[6]);
  a_r6_irq_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    vmask_q[0] |-> status[0] == irq);
  a_r8_rx_early_load: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_data[15:11] == 5'd17 |=> rx_early_th == $past(cmd_data[10:0]));
  a_r9_rx_on: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_data[15:11] == 5'd4 |=> rx_en);
  a_r9_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_data[15:11] == 5'd10 |=> !tx_en);
  a_r10_reset_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[12]) |-> status[15:13] == 3'd0 && !rx_en && !tx_en && !irq);
endmodule

bind nic_cmd_status nic_cmd_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
  .status(status), .irq(irq), .rx_en(rx_en), .tx_en(tx_en), .ev_q(ev_q),
  .vmask_q(vmask_q), .ev_tx_done(ev_tx_done), .rx_early_th(rx_early_th)
);

// File: tb/nic_cmd_status_bench.sv
module nic_cmd_status_bench;
  localparam int HOLD = 6;
  logic clk = 1'b0, rst_n = 1'b0, cmd_we = 1'b0;
  logic [15:0] cmd_data = '0;
  logic ev_fail = 0, ev_tx_done = 0, ev_tx_avail = 0, ev_rx_done = 0, ev_rx_early = 0, ev_stats = 0;
  logic [15:0] status;
  logic irq, rx_en, tx_en, rx_early_on, tx_avail_on, tx_start_on;
  logic [10:0] rx_early_th, tx_avail_th, tx_start_th;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nic_cmd_status #(.RESET_HOLD(HOLD)) u_nic_cmd_status (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .ev_fail(ev_fail), .ev_tx_done(ev_tx_done), .ev_tx_avail(ev_tx_avail),
    .ev_rx_done(ev_rx_done), .ev_rx_early(ev_rx_early), .ev_stats(ev_stats),
    .status(status), .irq(irq), .rx_en(rx_en), .tx_en(tx_en),
    .rx_early_th(rx_early_th), .tx_avail_th(tx_avail_th), .tx_start_th(tx_start_th),
    .rx_early_on(rx_early_on), .tx_avail_on(tx_avail_on), .tx_start_on(tx_start_on));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] op, logic [10:0] arg);
    @(negedge clk); cmd_we = 1'b1; cmd_data = {op, arg};
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic pulse(int idx);
    @(negedge clk);
    case (idx)
      1: ev_fail = 1; 2: ev_tx_done = 1; 3: ev_tx_avail = 1;
      4: ev_rx_done = 1; 5: ev_rx_early = 1; default: ev_stats = 1;
    endcase
    @(negedge clk);
    {ev_fail, ev_tx_done, ev_tx_avail, ev_rx_done, ev_rx_early, ev_stats} = '0;
  endtask

  task automatic t_reset;
    check("R1 status", status, 16'h0000);
    check("R1 irq", irq, 0);
    check("R1 enables", {rx_en, tx_en}, 0);
    check("R1 thresholds", {rx_early_th, tx_avail_th, tx_start_th}, {3{11'd2047}});
    check("R1 threshold flags", {rx_early_on, tx_avail_on, tx_start_on}, 0);
  endtask

  task automatic t_window;
    wr(5'd1, 11'h7F5); check("R2 window 5", status[15:13], 5);
    wr(5'd1, 11'd3);   check("R2 window 3", status[15:13], 3);
  endtask

  task automatic t_events;
    for (int i = 1; i <= 6; i++) pulse(i);
    check("R3 latched events", status[7:0], 8'hBE);
    check("R6 irq masked off", irq, 0);
  endtask

  task automatic t_ack;
    wr(5'd13, 11'h014); check("R4 ack bits 2,4", status[7:0], 8'hAA);
    @(negedge clk); cmd_we = 1; cmd_data = {5'd13, 11'h008}; ev_tx_avail = 1;
    @(negedge clk); cmd_we = 0; ev_tx_avail = 0;
    check("R4 event wins over ack", status[7:0], 8'hAA);
    wr(5'd13, 11'h0FF); check("R4 ack all", status[7:0], 8'h00);
  endtask

  task automatic t_reqint;
    wr(5'd12, 11'h7FF); check("R5 request interrupt", status[7:0], 8'h40);
  endtask

  task automatic t_irq;
    wr(5'd14, 11'h040); check("R6 irq on", irq, 1); check("R6 bit0", status[7:0], 8'h41);
    wr(5'd13, 11'h040); check("R6 irq cleared", {irq, status[7:0]}, 9'h000);
    pulse(4); check("R6 unmasked event no irq", {irq, status[7:0]}, 9'h010);
    wr(5'd14, 11'h010); check("R6 mask rx complete", {irq, status[7:0]}, 9'h111);
  endtask

  task automatic t_vmask;
    wr(5'd15, 11'h001); check("R7 hidden bit", status[7:0], 8'h01);
    check("R7 irq unaffected", irq, 1);
    wr(5'd15, 11'h0FF); check("R7 bit still latched", status[7:0], 8'h11);
    wr(5'd13, 11'h0FF); wr(5'd14, 11'h000);
    check("R7 cleanup", {irq, status[7:0]}, 9'h000);
  endtask

  task automatic t_thresh;
    wr(5'd17, 11'd100); check("R8 rx early", {rx_early_on, rx_early_th}, {1'b1, 11'd100});
    wr(5'd18, 11'd2047); check("R8 tx avail off", {tx_avail_on, tx_avail_th}, {1'b0, 11'd2047});
    wr(5'd19, 11'd0);   check("R8 tx start", {tx_start_on, tx_start_th}, {1'b1, 11'd0});
    wr(5'd18, 11'd2046); check("R8 2046 active", {tx_avail_on, tx_avail_th}, {1'b1, 11'd2046});
  endtask

  task automatic t_enables;
    wr(5'd4, 11'h7FF); check("R9 rx on", {rx_en, tx_en}, 2'b10);
    wr(5'd9, 11'd0);   check("R9 tx on", {rx_en, tx_en}, 2'b11);
    wr(5'd3, 11'd0);   check("R9 rx off", {rx_en, tx_en}, 2'b01);
    wr(5'd10, 11'd0);  check("R9 tx off", {rx_en, tx_en}, 2'b00);
  endtask

  task automatic t_ignored;
    wr(5'd1, 11'd6); wr(5'd4, 11'd0);
    wr(5'd2, 11'h7FF); wr(5'd5, 11'h7FF); wr(5'd8, 11'h7FF);
    wr(5'd11, 11'h7FF); wr(5'd16, 11'h7FF);
    check("R11 status unchanged", status, 16'hC000);
    check("R11 enables unchanged", {rx_en, tx_en}, 2'b10);
    check("R11 thresholds unchanged", {rx_early_th, tx_avail_th, tx_start_th},
          {11'd100, 11'd2046, 11'd0});
  endtask

  task automatic t_greset;
    pulse(2);
    wr(5'd0, 11'h123);
    for (int i = 0; i < HOLD; i++) begin
      check("R10 busy", status[12], 1);
      if (i == 2) check("R10 write ignored while busy", status[15:13], 6);
      if (i == 1) begin cmd_we = 1; cmd_data = {5'd1, 11'd2}; end
      @(negedge clk); cmd_we = 0;
    end
    check("R10 busy ends", status, 16'h0000);
    check("R10 enables reset", {rx_en, tx_en, irq}, 0);
    check("R10 thresholds reset", {rx_early_th, tx_avail_th, tx_start_th}, {3{11'd2047}});
    wr(5'd1, 11'd4); check("R10 commands accepted after", status[15:13], 4);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_window; t_events; t_ack; t_reqint; t_irq; t_vmask;
    t_thresh; t_enables; t_ignored; t_greset;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule